// File: doc/BRIEF.md
# Sixteen-Register Latched Datapath

This block is the execution half of a horizontally microcoded processor. It holds sixteen 16-bit registers, two operand latches, a left-operand selector, a four-function ALU, a one-bit shifter, a 12-bit address register and a 16-bit memory data register. The fields of the current microinstruction drive it directly: the selects, the function codes and the load enables come in as plain inputs.

A microinstruction runs over four subcycles, and the sequencer supplies the subcycle number on `phase`. The operand latches load in the second subcycle. The address register loads in the third. The memory data register and the register file load in the fourth.

The ALU result produces a negative flag and a zero flag, which the sequencer uses for branching. Five registers hold constants. They return to fixed values at reset and cannot be written. Register 2 is the conventional stack pointer. Register 6 holds the value one, so `sp := sp + 1` takes a single microinstruction.

Top module: `latched_datapath`

## Requirements
- R1: While `rst_n` is low, every general register, both latches, `mar` and `mbr` are cleared. The constant registers take these values: r5 = 0x0000, r6 = 0x0001, r7 = 0xFFFF, r8 = 0x0FFF, r9 = 0x00FF.
- R2: `phase` codes 0 to 3 stand for subcycles 1 to 4. On a clock edge with `phase` = 1, the A latch takes register `sel_a` and the B latch takes register `sel_b`. At every other phase both latches hold their values.
- R3: The ALU left operand is the A latch when `amux` = 1 and `mbr` when `amux` = 0. The right operand is always the B latch.
- R4: `alu_op` 0 adds modulo 2^16, 1 is bitwise AND, 2 passes the left operand, and 3 gives the bitwise complement of the left operand.
- R5: `sh_op` 0 passes the ALU result to `shift_out` unchanged. Code 1 shifts it right by one with a zero fill, code 2 shifts it left by one with a zero fill, and code 3 acts as no shift.
- R6: On an edge with `phase` = 2 and `ld_mar` = 1, `mar` takes bits 11:0 of the B latch. In every other case `mar` holds.
- R7: On an edge with `phase` = 3, `mbr` takes `shift_out` when `ld_mbr` = 1. Otherwise it takes `mem_rdata` when `mem_load` = 1. In every other case `mbr` holds.
- R8: On an edge with `phase` = 3 and `en_c` = 1, register `sel_c` takes `shift_out`, unless `sel_c` names a constant register.
- R9: `flag_n` equals bit 15 of the ALU result. `flag_z` is 1 exactly when all 16 bits of the ALU result are zero.
- R10: A write aimed at any of the registers r5 to r9 is ignored, and each of them keeps its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase | input | 2 | Subcycle number minus one |
| sel_a | input | 4 | Register captured in the A latch |
| sel_b | input | 4 | Register captured in the B latch |
| sel_c | input | 4 | Writeback destination register |
| amux | input | 1 | Left operand select: 1 = A latch, 0 = mbr |
| alu_op | input | 2 | ALU function code |
| sh_op | input | 2 | Shifter code |
| ld_mar | input | 1 | Address register load enable |
| ld_mbr | input | 1 | Load mbr from the shifter |
| en_c | input | 1 | Register writeback enable |
| mem_load | input | 1 | Load mbr from memory data |
| mem_rdata | input | 16 | Data arriving from memory |
| mar | output | 12 | Address register |
| mbr | output | 16 | Memory data register |
| shift_out | output | 16 | Shifter output |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The hardest case to reach from the ports is a register whose contents appear on no output. Such a value shows up only when it is latched in subcycle 2, routed through the ALU with the pass function, and stored to `mbr` in subcycle 4. The bench runs this read-back after a write that targets a constant register, and after the stack-pointer increment, to show whether the register changed. A long run with random fields and random phases then exercises enables that are asserted in the wrong subcycle. Those loads must have no effect, and the bench's model catches any that do.

// File: rtl/latched_datapath.sv
module latched_datapath #(
  parameter int DW    = 16,
  parameter int AW    = 12,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       phase,
  input  logic [SEL_W-1:0] sel_a,
  input  logic [SEL_W-1:0] sel_b,
  input  logic [SEL_W-1:0] sel_c,
  input  logic             amux,
  input  logic [1:0]       alu_op,
  input  logic [1:0]       sh_op,
  input  logic             ld_mar,
  input  logic             ld_mbr,
  input  logic             en_c,
  input  logic             mem_load,
  input  logic [DW-1:0]    mem_rdata,
  output logic [AW-1:0]    mar,
  output logic [DW-1:0]    mbr,
  output logic [DW-1:0]    shift_out,
  output logic             flag_n,
  output logic             flag_z
);
  localparam int NREG = 1 << SEL_W;
  localparam int C_FIRST = 5;
  localparam int C_LAST = 9;
  localparam logic [1:0] PH_READ = 2'd1;
  localparam logic [1:0] PH_ADDR = 2'd2;
  localparam logic [1:0] PH_WB = 2'd3;

  function automatic logic [DW-1:0] init_val(int idx);
    case (idx)
      6:       return DW'(1);
      7:       return '1;
      8:       return DW'((1 << AW) - 1);
      9:       return DW'(8'hFF);
      default: return '0;
    endcase
  endfunction

  function automatic logic is_const(logic [SEL_W-1:0] s);
    return int'(s) >= C_FIRST && int'(s) <= C_LAST;
  endfunction

  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] a_lat, b_lat, left_op, alu_y;

  assign left_op = amux ? a_lat : mbr;

  always_comb begin
    case (alu_op)
      2'd0:    alu_y = left_op + b_lat;
      2'd1:    alu_y = left_op & b_lat;
      2'd2:    alu_y = left_op;
      default: alu_y = ~left_op;
    endcase
  end

  always_comb begin
    case (sh_op)
      2'd1:    shift_out = {1'b0, alu_y[DW-1:1]};
      2'd2:    shift_out = {alu_y[DW-2:0], 1'b0};
      default: shift_out = alu_y;
    endcase
  end

  assign flag_n = alu_y[DW-1];
  assign flag_z = (alu_y == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= init_val(i);
    end else if (phase == PH_WB && en_c && !is_const(sel_c)) begin
      rf[sel_c] <= shift_out;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_lat <= '0;
      b_lat <= '0;
    end else if (phase == PH_READ) begin
      a_lat <= rf[sel_a];
      b_lat <= rf[sel_b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        mar <= '0;
    else if (phase == PH_ADDR && ld_mar) mar <= b_lat[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                mbr <= '0;
    else if (phase == PH_WB) begin
      if (ld_mbr)              mbr <= shift_out;
      else if (mem_load)       mbr <= mem_rdata;
    end
  end
endmodule

// File: rtl/latched_datapath_chk.sv
module latched_datapath_chk #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    phase,
  input logic          ld_mar,
  input logic          ld_mbr,
  input logic          mem_load,
  input logic [DW-1:0] mem_rdata,
  input logic [DW-1:0] shift_out,
  input logic [AW-1:0] mar,
  input logic [DW-1:0] mbr,
  input logic [DW-1:0] a_lat,
  input logic [DW-1:0] b_lat,
  input logic [DW-1:0] reg_one
);
  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd1 |=> $stable(a_lat) && $stable(b_lat));

  assert_mar_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase == 2'd2 && ld_mar) |=> $stable(mar));

  assert_mar_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd2 && ld_mar |=> mar == $past(b_lat[AW-1:0]));

  assert_mbr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3 |=> $stable(mbr));

  assert_mbr_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd3 && ld_mbr |=> mbr == $past(shift_out));

  assert_mbr_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd3 && !ld_mbr && mem_load |=> mbr == $past(mem_rdata));

  assert_const_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_one == DW'(1));
endmodule

bind latched_datapath latched_datapath_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .ld_mar(ld_mar), .ld_mbr(ld_mbr),
  .mem_load(mem_load), .mem_rdata(mem_rdata), .shift_out(shift_out),
  .mar(mar), .mbr(mbr), .a_lat(a_lat), .b_lat(b_lat), .reg_one(rf[6])
);

// File: tb/test_latched_datapath.sv
module test_latched_datapath;
  logic clk = 0, rst_n = 0;
  logic [1:0] phase = 0, alu_op = 0, sh_op = 0;
  logic [3:0] sel_a = 0, sel_b = 0, sel_c = 0;
  logic amux = 0, ld_mar = 0, ld_mbr = 0, en_c = 0, mem_load = 0;
  logic [15:0] mem_rdata = 0;
  logic [11:0] mar;
  logic [15:0] mbr, shift_out;
  logic flag_n, flag_z;

  int checks = 0, fails = 0;
  logic [15:0] m_rf [16];
  logic [15:0] m_a, m_b, m_mbr;
  logic [11:0] m_mar;

  always #10 clk = ~clk;

  latched_datapath i_latched_datapath (
    .clk(clk), .rst_n(rst_n), .phase(phase), .sel_a(sel_a), .sel_b(sel_b),
    .sel_c(sel_c), .amux(amux), .alu_op(alu_op), .sh_op(sh_op),
    .ld_mar(ld_mar), .ld_mbr(ld_mbr), .en_c(en_c), .mem_load(mem_load),
    .mem_rdata(mem_rdata), .mar(mar), .mbr(mbr), .shift_out(shift_out),
    .flag_n(flag_n), .flag_z(flag_z)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] m_alu();
    logic [15:0] l = amux ? m_a : m_mbr;
    case (alu_op)
      0: return l + m_b;
      1: return l & m_b;
      2: return l;
      default: return ~l;
    endcase
  endfunction

  function automatic logic [15:0] m_shift();
    logic [15:0] r = m_alu();
    if (sh_op == 1) return r >> 1;
    if (sh_op == 2) return r << 1;
    return r;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 16; i++) m_rf[i] = 16'h0000;
    m_rf[6] = 16'h0001; m_rf[7] = 16'hFFFF; m_rf[8] = 16'h0FFF; m_rf[9] = 16'h00FF;
    m_a = 0; m_b = 0; m_mbr = 0; m_mar = 0;
  endtask

  task automatic compare_all();
    logic [15:0] y = m_alu();
    check("R3/R4/R5 shift_out", shift_out, m_shift());
    check("R9 flag_n", flag_n, y[15]);
    check("R9 flag_z", flag_z, y == 0);
    check("R6 mar", mar, m_mar);
    check("R7 mbr", mbr, m_mbr);
  endtask

  task automatic step();
    logic [15:0] y = m_shift();
    logic [1:0] ph = phase;
    @(posedge clk);
    if (ph == 1) begin m_a = m_rf[sel_a]; m_b = m_rf[sel_b]; end
    if (ph == 2 && ld_mar) m_mar = m_b[11:0];
    if (ph == 3) begin
      if (ld_mbr) m_mbr = y;
      else if (mem_load) m_mbr = mem_rdata;
      if (en_c && !(sel_c >= 5 && sel_c <= 9)) m_rf[sel_c] = y;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic micro(input logic [3:0] a, b, c, input logic am, input logic [1:0] op, sh,
                       input logic lm, lb, ec, ml, input logic [15:0] md);
    sel_a = a; sel_b = b; sel_c = c; amux = am; alu_op = op; sh_op = sh;
    ld_mar = lm; ld_mbr = lb; en_c = ec; mem_load = ml; mem_rdata = md;
    for (int p = 0; p < 4; p++) begin
      phase = 2'(p);
      step();
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 mar reset", mar, 12'h000);
    check("R1 mbr reset", mbr, 16'h0000);
    rst_n = 1;
    @(negedge clk);
    compare_all();

    // R8 R6: mar := sp; sp := sp + 1
    micro(6, 2, 2, 1, 0, 0, 1, 0, 1, 0, 16'h0);
    check("R6 mar takes old sp", mar, 12'h000);
    // read sp back through pass into mbr
    micro(2, 0, 0, 1, 2, 0, 0, 1, 0, 0, 16'h0);
    check("R8 sp incremented", mbr, 16'h0001);

    // R10: write all-ones into r6, then read r6 back
    micro(7, 0, 6, 1, 2, 0, 0, 0, 1, 0, 16'h0);
    micro(6, 0, 0, 1, 2, 0, 0, 1, 0, 0, 16'h0);
    check("R10 r6 unchanged", mbr, 16'h0001);

    // R7: memory load, then R3 left operand from mbr
    micro(0, 0, 0, 0, 2, 0, 0, 0, 0, 1, 16'h8421);
    check("R7 mbr from memory", mbr, 16'h8421);
    micro(0, 8, 0, 0, 0, 0, 1, 0, 0, 0, 16'h0);
    check("R3 amux=0 add mbr+r8", shift_out, 16'h9420);
    check("R6 mar from r8", mar, 12'hFFF);
    check("R9 negative", flag_n, 1'b1);

    // R4 R5: complement with shifts; R9 zero
    micro(7, 0, 3, 1, 3, 0, 0, 0, 1, 0, 16'h0);
    check("R9 zero flag", flag_z, 1'b1);
    micro(9, 7, 4, 1, 1, 2, 0, 1, 1, 0, 16'h0);
    check("R5 left shift of AND", mbr, 16'h01FE);
    micro(7, 0, 4, 1, 2, 1, 0, 1, 1, 0, 16'h0);
    check("R5 right shift zero fill", mbr, 16'h7FFF);
    micro(8, 0, 0, 1, 2, 3, 0, 1, 0, 0, 16'h0);
    check("R5 code 3 no shift", mbr, 16'h0FFF);

    // R2 R6 R7 R8: random fields, phases out of order
    for (int n = 0; n < 600; n++) begin
      sel_a = 4'($urandom); sel_b = 4'($urandom); sel_c = 4'($urandom);
      amux = 1'($urandom); alu_op = 2'($urandom); sh_op = 2'($urandom);
      ld_mar = 1'($urandom); ld_mbr = 1'($urandom); en_c = 1'($urandom);
      mem_load = 1'($urandom); mem_rdata = 16'($urandom);
      phase = (n % 5 == 0) ? 2'($urandom) : 2'(n % 4);
      step();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule